// File: doc/BRIEF.md
# Pipelined-Address Synchronous SRAM Access Controller

This block is the synchronous control front end of a single-ported burst SRAM with a shared data bus, running on the rising clock edge. It takes two address strobes, three chip enables, a global write, a byte-write enable and one write select per byte lane. From these it decides at each clock rise whether an access starts and of what kind. It holds a registered access address, drives write enables into a small behavioural storage array and controls when the read data drives the shared bus.

The two strobes differ. The processor strobe takes priority over the controller strobe and needs chip enable 1 active. On an access started by the processor strobe, the write controls and data are taken one cycle after the address is captured. The controller strobe decides read or write in the same cycle that it captures the address. The bidirectional bus is modelled as a read-data output plus a drive-enable output, which a pad ring turns into a three-state driver.

The behavioural array holds 2**MEM_AW words. A 19-bit address picks its word by XOR-folding the address into MEM_AW bits, so an address below 2**MEM_AW maps to its own word.

Top module: `syncram_ctl`

## Requirements
- R1: A read starts at a clock rise when a strobe is accepted, all chip enables are active (ce1_n=0, ce2=1, ce3_n=0) and gw_n=1, bwe_n=1. In the next cycle, if oe_n=0 and no write is detected, dq_oe=1 and dq_out carries the stored word of the captured address.
- R2: When ce1_n=1, adr_proc_n=0 starts no access. The controller strobe is ignored in that cycle too, because the processor strobe is low.
- R3: At a processor-strobe capture the write controls are ignored. If gw_n=0, or bwe_n=0 with some bsel_n bit low, at the following rise, that cycle's dq_in is written to the captured address. A new processor capture in that cycle cancels the pending write. An accepted controller-strobe write in that cycle goes to the controller's address instead.
- R4: adr_ctl_n=0 with adr_proc_n=1, all chip enables active and a write combination present writes dq_in at the presented address in the same cycle. When both strobes are low, the access behaves as a processor-strobe access.
- R5: Lane i is dq bits [9i+8:9i], and bit 9i+8 is that lane's parity. With gw_n=1 and bwe_n=0, only lanes whose bsel_n[i]=0 are written, and the other lanes keep their contents. bwe_n=0 with all bsel_n high is not a write.
- R6: gw_n=0 writes all four lanes, whatever the values of bwe_n and bsel_n.
- R7: In any cycle in which a write takes place, dq_oe=0 whatever the value of oe_n.
- R8: With oe_n=1, dq_oe=0 and dq_out=0.
- R9: A cycle with no strobe, or with a strobe while any chip enable is inactive, changes no stored word. The next cycle does not drive the bus.
- R10: While rst_n=0, and in the first cycle after it, dq_oe=0, and any pending processor-strobe write is dropped.
- R11: Read data drives the bus only in the single cycle right after the capture. A following cycle with no new access does not drive it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adr_proc_n | input | 1 | Processor address strobe, active low, higher priority |
| adr_ctl_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable 1, active low, also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Access address |
| dq_in | input | LANES*(BYTE_W+1) | Write data from the bus |
| dq_out | output | LANES*(BYTE_W+1) | Read data toward the bus, zero when not driving |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench goes after both strobes low together. A design that let the controller strobe win would write or read in the capture cycle instead of deferring to the data phase. It checks that write controls shown during a processor capture are ignored, since a design that honoured them would corrupt the word one cycle early. It also checks that a byte write with bwe_n low and no lane selected counts as a read, and that gw_n overrides a partial lane mask. A design that got either wrong would leave lanes stale or overwrite them. Finally it checks that the bus floats during pending writes with oe_n low and after deselected strobes. It also checks that read data lasts exactly one cycle, because a design holding the drive enable would collide with the next writer.

// File: rtl/syncram_pkg.sv
`timescale 1ns/1ps
package syncram_pkg;

    // Access decided at a clock rise
    typedef enum logic [1:0] {
        KIND_IDLE   = 2'd0,
        KIND_PROC   = 2'd1,
        KIND_CTL_RD = 2'd2,
        KIND_CTL_WR = 2'd3
    } access_kind_e;

endpackage

// File: rtl/syncram_decode.sv
`timescale 1ns/1ps
module syncram_decode
    import syncram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             adr_proc_n,
    input  logic             adr_ctl_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output access_kind_e     kind,
    output logic [LANES-1:0] lane_mask
);

    logic chips_on;

    always_comb begin
        chips_on = !ce1_n && ce2 && !ce3_n;

        // global write beats the byte path; byte path needs a selected lane
        if (!gw_n) begin
            lane_mask = '1;
        end else if (!bwe_n) begin
            lane_mask = ~bsel_n;
        end else begin
            lane_mask = '0;
        end

        kind = KIND_IDLE;
        if (!adr_proc_n) begin
            // processor strobe owns the cycle; controller strobe is ignored
            if (chips_on) begin
                kind = KIND_PROC;
            end
        end else if (!adr_ctl_n && chips_on) begin
            kind = (|lane_mask) ? KIND_CTL_WR : KIND_CTL_RD;
        end
    end

endmodule

// File: rtl/syncram_seq.sv
`timescale 1ns/1ps
module syncram_seq
    import syncram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int MEM_AW = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  access_kind_e      kind,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [MEM_AW-1:0] wr_idx,
    output logic [LANES-1:0]  wr_lanes,
    output logic [MEM_AW-1:0] rd_idx,
    output logic              rd_valid
);

    typedef struct packed {
        logic [MEM_AW-1:0] idx;
        logic              pend;
        logic              rdv;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [MEM_AW-1:0] cap_idx;

    // fold the full address into the array index
    always_comb begin
        cap_idx = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            cap_idx[i % MEM_AW] = cap_idx[i % MEM_AW] ^ addr[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        wr_en    = 1'b0;
        wr_idx   = st_q.idx;
        wr_lanes = lane_mask;
        case (kind)
            KIND_PROC: begin
                st_d.idx  = cap_idx;
                st_d.pend = 1'b1;
                st_d.rdv  = 1'b1;
            end
            KIND_CTL_WR: begin
                st_d.idx  = cap_idx;
                st_d.pend = 1'b0;
                st_d.rdv  = 1'b0;
                wr_en     = 1'b1;
                wr_idx    = cap_idx;
            end
            KIND_CTL_RD: begin
                st_d.idx  = cap_idx;
                st_d.pend = 1'b0;
                st_d.rdv  = 1'b1;
            end
            default: begin
                // data phase of a processor-strobe access
                if (st_q.pend && (|lane_mask)) begin
                    wr_en = 1'b1;
                end
                st_d.pend = 1'b0;
                st_d.rdv  = 1'b0;
            end
        endcase
        rd_idx   = st_q.idx;
        rd_valid = st_q.rdv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PROC_CAPTURE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_PROC) |-> !wr_en); // R3

    AST_DATA_PHASE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_PROC) ##1 (wr_en && kind == KIND_IDLE) |-> (wr_idx == $past(cap_idx))); // R3

    AST_IDLE_NO_NEW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_IDLE) |=> !rd_valid); // R11

endmodule

// File: rtl/syncram_array.sv
`timescale 1ns/1ps
module syncram_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int MEM_AW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [MEM_AW-1:0]       wr_idx,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [MEM_AW-1:0]       rd_idx,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << MEM_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) begin
                store[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = store[rd_idx];
    end

    AST_WRITE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_lanes != '0)); // R5

endmodule

// File: rtl/syncram_ctl.sv
`timescale 1ns/1ps
module syncram_ctl
    import syncram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int MEM_AW = 6,
    localparam int LANE_W = BYTE_W + 1,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adr_proc_n,
    input  logic              adr_ctl_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    access_kind_e      kind;
    logic [LANES-1:0]  lane_mask;
    logic              wr_en;
    logic [MEM_AW-1:0] wr_idx;
    logic [LANES-1:0]  wr_lanes;
    logic [MEM_AW-1:0] rd_idx;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;

    syncram_decode #(.LANES(LANES)) u_decode (
        .adr_proc_n (adr_proc_n),
        .adr_ctl_n  (adr_ctl_n),
        .ce1_n      (ce1_n),
        .ce2        (ce2),
        .ce3_n      (ce3_n),
        .gw_n       (gw_n),
        .bwe_n      (bwe_n),
        .bsel_n     (bsel_n),
        .kind       (kind),
        .lane_mask  (lane_mask)
    );

    syncram_seq #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .LANES(LANES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .lane_mask (lane_mask),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_lanes  (wr_lanes),
        .rd_idx    (rd_idx),
        .rd_valid  (rd_valid)
    );

    syncram_array #(.LANES(LANES), .LANE_W(LANE_W), .MEM_AW(MEM_AW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_lanes (wr_lanes),
        .wr_data  (dq_in),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    // bus drive: only read data of last capture, never during a write
    always_comb begin
        dq_oe  = !oe_n && rd_valid && !wr_en;
        dq_out = dq_oe ? rd_data : '0;
    end

    AST_OE_HIGH_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dq_oe && dq_out == '0)); // R8

    AST_CTL_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n && adr_proc_n && !adr_ctl_n && !ce1_n && ce2 && !ce3_n) |-> !dq_oe); // R7

    AST_CE1_BLOCKS_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && !adr_proc_n) |=> !dq_oe); // R2

endmodule

// File: tb/syncram_ctl_bench.sv
`timescale 1ns/1ps
module syncram_ctl_bench;

    localparam int DW = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ap, ac, c1, c2, c3, gw, bwe, oe;
    logic [3:0]    bs;
    logic [18:0]   addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [DW-1:0] m_mem [64];
    logic [5:0]    m_idx  = '0;
    logic          m_pend = 1'b0;
    logic          m_rdv  = 1'b0;

    always #2.5 clk = ~clk;

    syncram_ctl u_syncram_ctl (
        .clk(clk), .rst_n(rst_n), .adr_proc_n(ap), .adr_ctl_n(ac),
        .ce1_n(c1), .ce2(c2), .ce3_n(c3), .gw_n(gw), .bwe_n(bwe),
        .bsel_n(bs), .oe_n(oe), .addr(addr), .dq_in(din),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // control bits: ap ac ce1_n ce2 ce3_n gw_n bwe_n bsel_n[3:0] oe_n
    localparam logic [11:0] IDLE_RD = 12'b11_010_11_1111_0;
    localparam logic [11:0] IDLE_HZ = 12'b11_010_11_1111_1;

    localparam int NV = 30;
    // {tag, control, address, data}
    localparam logic [57:0] VEC [NV] = '{
        {4'd4,  12'b10_010_01_1111_1, 6'd1, 36'h123456789}, // R4 ctl full write A @1
        {4'd4,  12'b10_010_01_1111_1, 6'd2, 36'h9ABCDEF01}, // R4 ctl full write B @2
        {4'd3,  12'b01_010_01_1111_1, 6'd3, 36'h111111111}, // R3 proc capture, gw ignored
        {4'd3,  12'b11_010_01_1111_0, 6'd0, 36'h0F0F0F0F0}, // R3 data phase write C @3, R7 float
        {4'd1,  12'b10_010_11_1111_0, 6'd1, 36'h000000000}, // R1 ctl read @1
        {4'd1,  IDLE_RD,              6'd0, 36'h000000000}, // R1 drive A
        {4'd11, IDLE_RD,              6'd0, 36'h000000000}, // R11 no hold
        {4'd1,  12'b01_010_11_1111_0, 6'd2, 36'h000000000}, // R1 proc read @2
        {4'd1,  IDLE_RD,              6'd0, 36'h000000000}, // R1 drive B
        {4'd5,  12'b10_010_10_1010_0, 6'd1, 36'hFFFFFFFFF}, // R5 lanes 0,2 @1, R7
        {4'd3,  12'b01_010_11_1111_0, 6'd2, 36'h000000000}, // R3 proc capture @2
        {4'd5,  12'b11_010_10_0111_0, 6'd0, 36'h5A5A5A5A5}, // R5 lane 3 @2 data phase, R7
        {4'd4,  12'b00_010_11_1111_0, 6'd1, 36'h000000000}, // R4 both low -> proc read @1
        {4'd4,  IDLE_RD,              6'd0, 36'h000000000}, // R4 drive merged @1
        {4'd2,  12'b01_110_11_1111_0, 6'd2, 36'h000000000}, // R2 ce1 high, ignored
        {4'd2,  IDLE_RD,              6'd0, 36'h000000000}, // R2 no drive
        {4'd9,  12'b10_000_01_1111_1, 6'd2, 36'h222222222}, // R9 ce2 low write ignored
        {4'd9,  12'b01_010_11_1111_0, 6'd2, 36'h000000000}, // R9 proc read @2
        {4'd9,  IDLE_RD,              6'd0, 36'h000000000}, // R9 @2 unchanged
        {4'd8,  12'b10_010_11_1111_0, 6'd3, 36'h000000000}, // R8 ctl read @3
        {4'd8,  IDLE_HZ,              6'd0, 36'h000000000}, // R8 oe high floats
        {4'd5,  12'b10_010_10_1111_0, 6'd3, 36'h333333333}, // R5 no lane -> read @3
        {4'd5,  IDLE_RD,              6'd0, 36'h000000000}, // R5 drive C
        {4'd6,  12'b10_010_00_1110_1, 6'd3, 36'h876543210}, // R6 gw overrides mask @3
        {4'd6,  12'b01_010_11_1111_0, 6'd3, 36'h000000000}, // R6 proc read @3
        {4'd6,  IDLE_RD,              6'd0, 36'h000000000}, // R6 drive full word
        {4'd3,  12'b01_010_11_1111_1, 6'd4, 36'h000000000}, // R3 proc capture @4
        {4'd3,  12'b10_010_01_1111_0, 6'd5, 36'hABCABCABC}, // R3 ctl write wins -> @5
        {4'd3,  12'b10_010_11_1111_0, 6'd5, 36'h000000000}, // R3 ctl read @5
        {4'd3,  IDLE_RD,              6'd0, 36'h000000000}  // R3 drive @5
    };

    task automatic check(input int tag, input logic e_oe, input logic [DW-1:0] e_out);
        checks++;
        if (dq_oe !== e_oe || dq_out !== e_out) begin
            fails++;
            $display("FAIL R%0d: oe=%0b out=%h expected oe=%0b out=%h",
                     tag, dq_oe, dq_out, e_oe, e_out);
        end
    endtask

    task automatic step(input logic [11:0] c, input logic [5:0] a,
                        input logic [DW-1:0] d, input int tag);
        logic ce_ok, ps, cs, wr, e_oe;
        logic [3:0] mask;
        logic [5:0] tgt;
        logic [DW-1:0] e_out;
        @(negedge clk);
        {ap, ac, c1, c2, c3, gw, bwe, bs, oe} = c;
        addr = {13'b0, a};
        din  = d;
        #1;
        ce_ok = !c1 && c2 && !c3;
        ps    = !ap && ce_ok;
        cs    = ap && !ac && ce_ok;
        mask  = !gw ? 4'hF : (!bwe ? ~bs : 4'h0);
        wr    = (mask != 0) && (cs || (m_pend && !ps));
        e_oe  = !oe && m_rdv && !wr;
        e_out = e_oe ? m_mem[m_idx] : '0;
        check(tag, e_oe, e_out);
        @(posedge clk);
        if (wr) begin
            tgt = cs ? a : m_idx;
            for (int l = 0; l < 4; l++)
                if (mask[l]) m_mem[tgt][l*9 +: 9] = d[l*9 +: 9];
        end
        m_rdv  = ps || (cs && mask == 0);
        m_pend = ps;
        if (ps || cs) m_idx = a;
    endtask

    initial begin
        {ap, ac, c1, c2, c3, gw, bwe, bs, oe} = IDLE_RD;
        addr = '0;
        din  = '0;
        // R10 reset state
        repeat (3) @(negedge clk);
        check(10, 1'b0, '0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][53:42], VEC[i][41:36], VEC[i][35:0], int'(VEC[i][57:54]));
        end
        // R10 reset drops a pending capture and its drive
        step(12'b01_010_11_1111_0, 6'd1, '0, 10);
        @(negedge clk);
        rst_n = 1'b0;
        {ap, ac, c1, c2, c3, gw, bwe, bs, oe} = 12'b11_010_01_1111_0;
        din = 36'h444444444;
        #1;
        check(10, 1'b0, '0);
        m_rdv  = 1'b0;
        m_pend = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(12'b11_010_01_1111_0, 6'd0, 36'h444444444, 10); // R10 no stale write
        step(12'b10_010_11_1111_0, 6'd1, '0, 10);
        step(IDLE_RD, 6'd0, '0, 10);                          // R10 @1 intact
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule